// File: doc/BRIEF.md
# First-Word-Fall-Through Dual-Clock FIFO with Echoed Read Strobe

A two-clock FIFO in first-word-fall-through form. Words are written on the write clock under an active-low write enable. The oldest stored word moves on its own into an output register on the read clock, with no read request needed. An active-low ready flag reports that this register holds a valid word. An active-low read enable consumes the held word, and the next stored word replaces it in the same edge.

Each time a fresh word enters the output register, the read side pulls an echo strobe low for one read-clock cycle. A copy of the read clock is driven out beside the strobe. Downstream logic can therefore capture every new word against a matched clock, without having to infer loads from the read enable.

The data bus is a tri-state output. A chip select and an output enable, both active low, must both be asserted for the bus to be driven. Chip select must lead the read enable by at least one cycle, so that the held word appears on the bus before it is consumed. Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Writes made while the FIFO is full are dropped.

Top module: `fwft_echo_fifo`

## Requirements
- R1: While rst_ni is low, out_rdy_no is 1, echo_ren_no is 1, full_o is 0 and the output register is cleared.
- R2: When the FIFO is empty, a word written into it is loaded into the output register without any read enable. In the cycle after that load, out_rdy_no is 0.
- R3: echo_ren_no is 0 in exactly those read-clock cycles that follow an edge where the output register was loaded. A load happens only when the register was empty or was being read at that edge. During back-to-back reads that each load a word, the strobe stays at 0.
- R4: Words leave the output register in the order in which they were accepted. Each word marked by echo_ren_no = 0 is the next accepted word.
- R5: While out_rdy_no is 0 and rd_en_ni is 1, the held word, out_rdy_no and the data stay unchanged, and echo_ren_no is 1.
- R6: An enabled read of the held word when nothing more is stored sets out_rdy_no to 1 and echo_ren_no to 1 on that edge.
- R7: q_o is driven with the held word only while rd_cs_ni = 0 and oe_ni = 0. Otherwise it is high-impedance.
- R8: rd_ni may be 0 at a read-clock edge only if rd_cs_ni was 0 at the previous read-clock edge.
- R9: full_o is 1 once 2**ADDR_W words are stored behind the output register. With the output register also full, this makes 2**ADDR_W + 1 words accepted in all. A write attempted while full_o is 1 changes nothing.
- R10: echo_rclk_o follows rclk_i.
- R11: A word written into an empty FIFO reaches the output register no earlier than the third read-clock rising edge after the write edge. The delay comes from the write-pointer register and two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wr_en_ni | input | 1 | Write enable, active low |
| wr_data_i | input | DATA_W | Write data |
| full_o | output | 1 | Storage full, write domain |
| rd_en_ni | input | 1 | Read enable, active low |
| rd_cs_ni | input | 1 | Read chip select, active low, gates the bus |
| oe_ni | input | 1 | Output enable, active low, gates the bus |
| q_o | output | DATA_W | Tri-state read data |
| out_rdy_no | output | 1 | Output register empty when 1 |
| echo_ren_no | output | 1 | Low for one read cycle after each output-register load |
| echo_rclk_o | output | 1 | Copy of the read clock |

## Verification
Several rules are checked by assertions on every read or write edge:
- the echo strobe is low only while a word is held;
- an empty register with stored data is always filled on the next edge, and the strobe fires;
- a held word without a read enable stays frozen;
- reading the last word empties the register;
- chip select leads the read enable;
- a write while full leaves the write pointer still.

Data order, the count of words accepted at full, bus high-impedance under each gating input, and the synchronizer latency from write to visibility depend on sequences across both clock domains. The bench's directed and random scenarios show these.

// File: rtl/fwft_echo_pkg.sv
package fwft_echo_pkg;
  typedef enum logic {
    OREG_EMPTY = 1'b0,
    OREG_HELD  = 1'b1
  } oreg_state_e;
endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fwft_mem.sv
module fwft_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read side only addresses slots already published through the synchronizer
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fwft_wr_side.sv
module fwft_wr_side #(
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_ni,
  input  logic [PTR_W-1:0]  rgray_sync_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [PTR_W-1:0]  wgray_o,
  output logic              full_o
);
  logic [PTR_W-1:0] wbin_q, wbin_n, wgray_q, rgray_flip;

  // full when pointers differ only in the two top Gray bits
  assign rgray_flip = {~rgray_sync_i[PTR_W-1:PTR_W-2], rgray_sync_i[PTR_W-3:0]};
  assign full_o     = (wgray_q == rgray_flip);
  assign we_o       = !wr_en_ni && !full_o;
  assign wbin_n     = wbin_q + PTR_W'(we_o);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr_o = wbin_q[ADDR_W-1:0];
  assign wgray_o = wgray_q;

  assert_full_drop_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && !wr_en_ni) |=> $stable(wbin_q));
endmodule

// File: rtl/fwft_rd_side.sv
module fwft_rd_side
  import fwft_echo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              rd_en_ni,
  input  logic              rd_cs_ni,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic [DATA_W-1:0] oreg_o,
  output logic              out_rdy_no,
  output logic              echo_ren_no
);
  oreg_state_e       state_q;
  logic [PTR_W-1:0]  rbin_q, rbin_n, rgray_q;
  logic [DATA_W-1:0] oreg_q;
  logic              echo_n_q, cs_q;
  logic              mem_empty, take, load;

  assign mem_empty = (rgray_q == wgray_sync_i);
  assign take      = (state_q == OREG_HELD) && !rd_en_ni;
  // refill when the register is empty or being read this edge
  assign load      = !mem_empty && ((state_q == OREG_EMPTY) || take);
  assign rbin_n    = rbin_q + PTR_W'(load);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      oreg_q   <= '0;
      state_q  <= OREG_EMPTY;
      echo_n_q <= 1'b1;
      cs_q     <= 1'b1;
    end else begin
      rbin_q   <= rbin_n;
      rgray_q  <= rbin_n ^ (rbin_n >> 1);
      echo_n_q <= !load;
      cs_q     <= rd_cs_ni;
      if (load) begin
        oreg_q  <= mem_rdata_i;
        state_q <= OREG_HELD;
      end else if (take) begin
        state_q <= OREG_EMPTY;
      end
    end
  end

  assign raddr_o     = rbin_q[ADDR_W-1:0];
  assign rgray_o     = rgray_q;
  assign oreg_o      = oreg_q;
  assign out_rdy_no  = (state_q == OREG_EMPTY);
  assign echo_ren_no = echo_n_q;

  assert_echo_valid_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !echo_n_q |-> (state_q == OREG_HELD));

  assert_fall_through_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (state_q == OREG_EMPTY && !mem_empty) |=> (state_q == OREG_HELD && !echo_n_q));

  assert_hold_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (state_q == OREG_HELD && rd_en_ni) |=> (state_q == OREG_HELD && $stable(oreg_q) && echo_n_q));

  assert_last_read_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (take && mem_empty) |=> (state_q == OREG_EMPTY && echo_n_q));

  assert_cs_lead_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_en_ni |-> !cs_q);
endmodule

// File: rtl/fwft_echo_fifo.sv
module fwft_echo_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rd_en_ni,
  input  logic              rd_cs_ni,
  input  logic              oe_ni,
  output wire  [DATA_W-1:0] q_o,
  output logic              out_rdy_no,
  output logic              echo_ren_no,
  output logic              echo_rclk_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_rs, rgray_ws;
  logic [DATA_W-1:0] mem_rdata, oreg;
  logic              bus_en;

  fwft_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i      (wclk_i),
    .rst_ni      (rst_ni),
    .wr_en_ni    (wr_en_ni),
    .rgray_sync_i(rgray_ws),
    .we_o        (we),
    .waddr_o     (waddr),
    .wgray_o     (wgray),
    .full_o      (full_o)
  );

  fwft_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(mem_rdata)
  );

  fwft_sync #(.W(PTR_W)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_rs)
  );

  fwft_sync #(.W(PTR_W)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_ws)
  );

  fwft_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .rd_en_ni    (rd_en_ni),
    .rd_cs_ni    (rd_cs_ni),
    .wgray_sync_i(wgray_rs),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .oreg_o      (oreg),
    .out_rdy_no  (out_rdy_no),
    .echo_ren_no (echo_ren_no)
  );

  assign bus_en      = !rd_cs_ni && !oe_ni;
  assign q_o         = bus_en ? oreg : {DATA_W{1'bz}};
  assign echo_rclk_o = rclk_i;
endmodule

// File: tb/fwft_echo_fifo_tb.sv
module fwft_echo_fifo_tb;
  localparam int DW    = 16;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, rd_cs_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  tri1  [DW-1:0] q_bus;
  logic full, out_rdy_n, echo_n, echo_clk;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_word = '0;
  logic mon_en = 1'b0;
  logic prev_rdy_n = 1'b1;

  always #2ns wclk = ~wclk;
  always #3ns rclk = ~rclk;

  fwft_echo_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_ni(wr_en_n), .wr_data_i(wdata), .full_o(full),
    .rd_en_ni(rd_en_n), .rd_cs_ni(rd_cs_n), .oe_ni(oe_n),
    .q_o(q_bus), .out_rdy_no(out_rdy_n), .echo_ren_no(echo_n), .echo_rclk_o(echo_clk)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data never all ones, so a pulled-up idle bus is distinguishable
  function automatic logic [DW-1:0] gen_word();
    logic [DW-1:0] w;
    w = DW'($urandom);
    if (w == ONES) w = '0;
    return w;
  endfunction

  // a load is allowed only into an empty register or one being read
  function automatic bit load_allowed(input logic rdy_n_before, input logic ren_n);
    return rdy_n_before || !ren_n;
  endfunction

  task automatic wr_word(input bit en, input logic [DW-1:0] d, output bit acc);
    @(negedge wclk); #1ns;
    wr_en_n = !en;
    wdata   = d;
    acc     = en && !full;
    if (acc) exp_q.push_back(d);
  endtask

  task automatic rd_cycle(input bit ren);
    @(negedge rclk); #1ns;
    rd_en_n = !ren;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !out_rdy_n) && guard < 400) begin
      rd_cycle(1'b1);
      guard++;
    end
    rd_cycle(1'b0);
    check(exp_q.size() == 0, "R4 all accepted words delivered", DW'(exp_q.size()), '0);
  endtask

  // read-side monitor: outputs reflect the rising edge just passed
  always @(negedge rclk) begin
    if (mon_en) begin
      if (!echo_n) begin
        check(load_allowed(prev_rdy_n, rd_en_n), "R3 echo without room", {15'd0, prev_rdy_n}, 16'd1);
        check(!out_rdy_n, "R2 ready low with new word", {15'd0, out_rdy_n}, '0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 word with none pending", q_bus, '0);
        end else begin
          last_word = exp_q.pop_front();
          if (!rd_cs_n && !oe_n) check(q_bus === last_word, "R4 word order", q_bus, last_word);
        end
      end else if (!prev_rdy_n && rd_en_n) begin
        check(!out_rdy_n, "R5 held word stays ready", {15'd0, out_rdy_n}, '0);
        if (!rd_cs_n && !oe_n) check(q_bus === last_word, "R5 held data stable", q_bus, last_word);
      end else if (!prev_rdy_n && !rd_en_n) begin
        check(out_rdy_n, "R6 read with no refill empties", {15'd0, out_rdy_n}, 16'd1);
      end
      prev_rdy_n = out_rdy_n;
    end
  end

  initial begin
    #800us;
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit a;
    int n;
    int acc_n;
    logic [DW-1:0] w0;
    void'($urandom(32'h5EED_1234));

    // R1 reset state
    #5ns;
    check(out_rdy_n === 1'b1, "R1 ready flag in reset", {15'd0, out_rdy_n}, 16'd1);
    check(echo_n === 1'b1, "R1 echo in reset", {15'd0, echo_n}, 16'd1);
    check(full === 1'b0, "R1 full in reset", {15'd0, full}, '0);
    check(q_bus === ONES, "R7 bus idle in reset", q_bus, ONES);
    @(negedge wclk); #1ns rst_n = 1'b1;
    #1ns mon_en = 1'b1;

    @(negedge rclk); #1ns rd_cs_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge rclk);

    // R11 / R2 first word falls through after synchronization
    w0 = gen_word();
    wr_word(1'b1, w0, a);
    @(posedge wclk); #1ns wr_en_n = 1'b1;
    n = 0;
    while (out_rdy_n && n < 12) begin
      @(negedge rclk);
      n++;
    end
    check(n >= 3 && n <= 5, "R11 sync latency in read cycles", DW'(n), 16'd3);
    check(!out_rdy_n, "R2 fall-through without read", {15'd0, out_rdy_n}, '0);

    // R7 bus gating with a valid held word
    #0.5ns check(q_bus === w0, "R7 bus driven when selected", q_bus, w0);
    oe_n = 1'b1;
    #0.5ns check(q_bus === ONES, "R7 high-Z with output enable off", q_bus, ONES);
    oe_n = 1'b0; rd_cs_n = 1'b1;
    #0.5ns check(q_bus === ONES, "R7 high-Z with chip select off", q_bus, ONES);
    rd_cs_n = 1'b0;

    // R10 echo clock
    @(negedge rclk); #0.5ns check(echo_clk === 1'b0, "R10 echo clock low", {15'd0, echo_clk}, '0);
    @(posedge rclk); #0.5ns check(echo_clk === 1'b1, "R10 echo clock high", {15'd0, echo_clk}, 16'd1);

    // R6 read of the only word
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    check(out_rdy_n === 1'b1, "R6 ready high after last read", {15'd0, out_rdy_n}, 16'd1);
    check(echo_n === 1'b1, "R6 echo high after last read", {15'd0, echo_n}, 16'd1);

    // R9 fill to full, extra writes dropped
    acc_n = 0;
    wr_word(1'b1, gen_word(), a); acc_n += int'(a);
    repeat (40) wr_word(1'b0, '0, a);
    for (int i = 0; i < DEPTH + 2; i++) begin
      wr_word(1'b1, gen_word(), a);
      acc_n += int'(a);
    end
    repeat (4) wr_word(1'b0, '0, a);
    check(acc_n == DEPTH + 1, "R9 accepted words at full", DW'(acc_n), DW'(DEPTH + 1));
    check(full === 1'b1, "R9 full flag", {15'd0, full}, 16'd1);
    drain();
    repeat (12) @(negedge wclk);
    check(full === 1'b0, "R9 full clears after drain", {15'd0, full}, '0);

    // random traffic, both domains at once
    fork
      begin
        for (int i = 0; i < 600; i++) wr_word($urandom_range(0, 9) < 6, gen_word(), a);
        wr_word(1'b0, '0, a);
      end
      begin
        for (int i = 0; i < 500; i++) rd_cycle($urandom_range(0, 9) < 5);
        rd_cycle(1'b0);
      end
    join
    drain();
    repeat (4) @(negedge rclk);
    check(out_rdy_n === 1'b1, "R6 empty after random traffic", {15'd0, out_rdy_n}, 16'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule